// File: doc/BRIEF.md
# Sync Error Rate Warning Flag

This block watches a stream of sync error strobes and raises an active-high warning flag only when those errors arrive faster than a chosen rate. A single error does not raise the flag. Errors must build up faster than the line rate drains them away.

The block holds an unsigned charge register that acts as a digital leaky integrator. Each sync error strobe adds a programmable step. Each line tick removes a programmable step. The charge saturates at zero and at its full-scale value.

A two-state machine compares the charge with a set level and a lower clear level. This forms a hysteresis band, so the flag does not chatter when the rate sits near the balance point. With a step up of 10, a step down of 1 and a set level near mid-scale, the balance point is one error in ten lines.

The two states are `ST_QUIET` (flag low) and `ST_WARN` (flag high). There are two transitions:
- `T_TRIP` goes from `ST_QUIET` to `ST_WARN` when the charge is at or above the set level.
- `T_RELEASE` goes from `ST_WARN` to `ST_QUIET` when the charge is below the clear level.

In every other case the state holds. The charge updates on the clock edge that samples a strobe or tick. The state updates on the following edge. The flag is decoded from the state, so it changes two clock edges after the input that causes the crossing.

Top module: `sync_err_rate_flag`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the charge to 0 and the flag to low; after reset the flag stays low until charge reaches the set level.
- R2: Each cycle with sync_err_i high and line_tick_i low adds step_up_i to the charge.
- R3: Each cycle with line_tick_i high and sync_err_i low subtracts step_dn_i from the charge, and the charge floors at 0 instead of wrapping.
- R4: In a cycle with both sync_err_i and line_tick_i high, the charge changes by step_up_i minus step_dn_i (addition first, then subtraction, then saturation).
- R5: When the flag is low and the charge is greater than or equal to thr_set_i, the flag goes high on the next clock edge (equality trips).
- R6: When the flag is high and the charge is strictly below thr_clr_i, the flag goes low on the next clock edge; a charge equal to thr_clr_i keeps it high.
- R7: While thr_clr_i <= charge < thr_set_i, the flag keeps its previous value.
- R8: With steps 10 and 1 and levels 128/112, a sustained rate of one error per 9 lines eventually raises the flag, and a following rate of one error per 11 lines clears it.
- R9: Line ticks on an empty integrator leave it at 0, so that exactly ceil(thr_set_i / step_up_i) strobes are then needed to raise the flag.
- R10: The charge saturates at 2^ACC_W-1 (255 by default) instead of wrapping, so from saturation exactly (255 - thr_clr_i + 1) ticks clear the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_err_i | input | 1 | One-cycle strobe per detected sync error |
| line_tick_i | input | 1 | One-cycle strobe per video line (decay event) |
| step_up_i | input | ACC_W (8) | Charge added per error strobe |
| step_dn_i | input | ACC_W (8) | Charge removed per line tick |
| thr_set_i | input | ACC_W (8) | Level at or above which the flag sets |
| thr_clr_i | input | ACC_W (8) | Level below which the flag clears (<= thr_set_i) |
| warn_o | output | 1 | Active-high rate warning flag |

## Verification
The integrator is first driven with isolated bursts of strobes and ticks. These land the charge exactly on each threshold and one step past it. This separates the `>=` comparison from `>`, and separates the strict `<` release from `<=`.

Two further patterns start from the rails: long runs of ticks on an empty integrator, and long runs of strobes into a full one. The number of steps needed afterwards differs by many counts if the charge wraps instead of saturating.

A cycle with both a strobe and a tick, using a decrement of 3, lands on either side of the set level depending on whether both steps are applied. Finally, periodic error patterns at one per 9 and one per 11 lines show the rate balance. Throughout, a running model of the flag is compared every cycle.

// File: rtl/sew_pkg.sv
package sew_pkg;

    // Warning state machine encoding
    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_WARN  = 1'b1
    } sew_state_e;

    // Decoded transition tag (for observability in the FSM)
    typedef enum logic [1:0] {
        T_NONE    = 2'd0,
        T_TRIP    = 2'd1,
        T_RELEASE = 2'd2
    } sew_trans_e;

endpackage

// File: rtl/sew_leaky_integrator.sv
module sew_leaky_integrator #(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             charge_en,
    input  logic             drain_en,
    input  logic [ACC_W-1:0] charge_step,
    input  logic [ACC_W-1:0] drain_step,
    output logic [ACC_W-1:0] level
);

    localparam int SUM_W = ACC_W + 1;
    localparam logic [SUM_W-1:0] FULL_SCALE = {1'b0, {ACC_W{1'b1}}};

    logic [SUM_W-1:0] after_add;
    logic [SUM_W-1:0] after_sub;
    logic [ACC_W-1:0] level_next;

    // Add the error step first, into one extra bit of headroom
    always_comb begin
        after_add = {1'b0, level};
        if (charge_en) begin
            after_add = {1'b0, level} + {1'b0, charge_step};
        end
    end

    // Remove the line step, flooring at zero
    always_comb begin
        after_sub = after_add;
        if (drain_en) begin
            if (after_add < {1'b0, drain_step}) begin
                after_sub = '0;
            end else begin
                after_sub = after_add - {1'b0, drain_step};
            end
        end
    end

    // Clamp to full scale
    always_comb begin
        if (after_sub > FULL_SCALE) begin
            level_next = FULL_SCALE[ACC_W-1:0];
        end else begin
            level_next = after_sub[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            level <= level_next;
        end
    end

endmodule

// File: rtl/sew_hyst_fsm.sv
module sew_hyst_fsm
    import sew_pkg::*;
#(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] level,
    input  logic [ACC_W-1:0] set_level,
    input  logic [ACC_W-1:0] clr_level,
    output logic             warn
);

    sew_state_e state_q;
    sew_state_e state_d;
    sew_trans_e trans;

    logic at_or_above_set;
    logic below_clr;

    assign at_or_above_set = (level >= set_level);
    assign below_clr       = (level <  clr_level);

    // Next-state and transition decode
    always_comb begin
        state_d = state_q;
        trans   = T_NONE;
        unique case (state_q)
            ST_QUIET: begin
                if (at_or_above_set) begin
                    state_d = ST_WARN;
                    trans   = T_TRIP;
                end
            end
            ST_WARN: begin
                if (below_clr) begin
                    state_d = ST_QUIET;
                    trans   = T_RELEASE;
                end
            end
            default: begin
                state_d = ST_QUIET;
                trans   = T_NONE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_QUIET: warn = 1'b0;
            ST_WARN:  warn = 1'b1;
            default:  warn = 1'b0;
        endcase
    end

endmodule

// File: rtl/sync_err_rate_flag.sv
module sync_err_rate_flag #(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_err_i,
    input  logic             line_tick_i,
    input  logic [ACC_W-1:0] step_up_i,
    input  logic [ACC_W-1:0] step_dn_i,
    input  logic [ACC_W-1:0] thr_set_i,
    input  logic [ACC_W-1:0] thr_clr_i,
    output logic             warn_o
);

    logic [ACC_W-1:0] charge_q;
    logic             warn_w;

    sew_leaky_integrator #(
        .ACC_W(ACC_W)
    ) integ_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .charge_en  (sync_err_i),
        .drain_en   (line_tick_i),
        .charge_step(step_up_i),
        .drain_step (step_dn_i),
        .level      (charge_q)
    );

    sew_hyst_fsm #(
        .ACC_W(ACC_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (charge_q),
        .set_level(thr_set_i),
        .clr_level(thr_clr_i),
        .warn     (warn_w)
    );

    assign warn_o = warn_w;

endmodule

// File: rtl/sew_checker.sv
module sew_checker #(
    parameter int ACC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err,
    input logic             tick,
    input logic [ACC_W-1:0] up,
    input logic [ACC_W-1:0] dn,
    input logic [ACC_W-1:0] thr_set,
    input logic [ACC_W-1:0] thr_clr,
    input logic [ACC_W-1:0] charge,
    input logic             flag
);

    localparam logic [ACC_W:0] TOP = {1'b0, {ACC_W{1'b1}}};

    // R1: reset leaves flag and charge cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!flag && charge == '0));

    // R2: a lone strobe adds the step when no saturation is involved
    a_r2_strobe_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !tick && ({1'b0, charge} + {1'b0, up} <= TOP))
        |=> ({1'b0, charge} == {1'b0, $past(charge)} + {1'b0, $past(up)}));

    // R3: a lone tick subtracts the step
    a_r3_tick_subtracts: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !err && charge >= dn) |=> (charge == $past(charge) - $past(dn)));

    // R3: floor at zero
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !err && charge < dn) |=> (charge == '0));

    // R10: saturation at full scale
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !tick && ({1'b0, charge} + {1'b0, up} > TOP)) |=> (&charge));

    // R5: trip on reaching the set level
    a_r5_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && charge >= thr_set) |=> flag);

    // R6: release below the clear level
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && charge < thr_clr) |=> !flag);

    // R7: hold inside the band
    a_r7_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
        (charge < thr_set && charge >= thr_clr) |=> $stable(flag));

endmodule

bind sync_err_rate_flag sew_checker #(
    .ACC_W(ACC_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .err    (sync_err_i),
    .tick   (line_tick_i),
    .up     (step_up_i),
    .dn     (step_dn_i),
    .thr_set(thr_set_i),
    .thr_clr(thr_clr_i),
    .charge (charge_q),
    .flag   (warn_o)
);

// File: tb/sync_err_rate_flag_tb_top.sv
module sync_err_rate_flag_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync_err_i = 1'b0;
    logic         line_tick_i = 1'b0;
    logic [W-1:0] step_up_i = 8'd10;
    logic [W-1:0] step_dn_i = 8'd1;
    logic [W-1:0] thr_set_i = 8'd128;
    logic [W-1:0] thr_clr_i = 8'd112;
    logic         warn_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;

    always #10 clk = ~clk;

    sync_err_rate_flag #(.ACC_W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_err_i (sync_err_i),
        .line_tick_i(line_tick_i),
        .step_up_i  (step_up_i),
        .step_dn_i  (step_dn_i),
        .thr_set_i  (thr_set_i),
        .thr_clr_i  (thr_clr_i),
        .warn_o     (warn_o)
    );

    // Spec model of charge and flag (R2-R7, R10)
    int m_chg;
    bit m_flag;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_chg  <= 0;
            m_flag <= 1'b0;
        end else begin
            int nx;
            if (!m_flag && m_chg >= int'(thr_set_i)) m_flag <= 1'b1;
            else if (m_flag && m_chg < int'(thr_clr_i)) m_flag <= 1'b0;
            nx = m_chg;
            if (sync_err_i) nx = nx + int'(step_up_i);
            if (line_tick_i) nx = nx - int'(step_dn_i);
            if (nx < 0) nx = 0;
            if (nx > 255) nx = 255;
            m_chg <= nx;
        end
    end

    // Continuous comparison against the model (R5, R6, R7)
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            n_cmp++;
            if (warn_o !== m_flag) begin
                n_bad++;
                $display("FAIL R5/R6/R7 monitor t=%0t actual=%0b expected=%0b", $time, warn_o, m_flag);
            end
        end
    end

    task automatic check_flag(input bit exp, input string req);
        n_cmp++;
        if (warn_o !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, warn_o, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sync_err_i = 1'b0;
        line_tick_i = 1'b0;
        repeat (3) @(negedge clk);
        check_flag(1'b0, "R1 flag during reset");
        rst_n = 1'b1;
    endtask

    task automatic errs(input int n);
        for (int i = 0; i < n; i++) begin
            sync_err_i = 1'b1;
            @(negedge clk);
            sync_err_i = 1'b0;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            line_tick_i = 1'b1;
            @(negedge clk);
            line_tick_i = 1'b0;
        end
    endtask

    // Wait one edge so the state register follows the charge, then sample
    task automatic settle_check(input bit exp, input string req);
        @(negedge clk);
        check_flag(exp, req);
    endtask

    task automatic t_reset_state();
        do_reset();
        settle_check(1'b0, "R1 flag after reset");
        errs(1);
        settle_check(1'b0, "R1 one error does not trip");
    endtask

    task automatic t_empty_floor();
        do_reset();
        ticks(200);
        errs(12);
        settle_check(1'b0, "R9 120 below set");
        errs(1);
        settle_check(1'b1, "R9 R2 130 trips");
        ticks(18);
        settle_check(1'b1, "R6 at 112 holds");
        ticks(1);
        settle_check(1'b0, "R6 111 releases");
        errs(1);
        settle_check(1'b0, "R7 121 in band stays low");
        errs(1);
        settle_check(1'b1, "R7 R5 131 trips");
    endtask

    task automatic t_full_saturate();
        do_reset();
        errs(30);
        settle_check(1'b1, "R10 saturated high");
        ticks(143);
        settle_check(1'b1, "R10 112 after 143 ticks holds");
        ticks(1);
        settle_check(1'b0, "R10 111 after 144 ticks clears");
    endtask

    task automatic t_both_same_cycle();
        do_reset();
        step_dn_i = 8'd3;
        errs(12);
        sync_err_i = 1'b1;
        line_tick_i = 1'b1;
        @(negedge clk);
        sync_err_i = 1'b0;
        line_tick_i = 1'b0;
        settle_check(1'b0, "R4 120+10-3=127 stays low");
        errs(1);
        settle_check(1'b1, "R4 137 trips");
        step_dn_i = 8'd1;
    endtask

    task automatic t_custom_levels();
        thr_set_i = 8'd50;
        thr_clr_i = 8'd40;
        do_reset();
        errs(4);
        settle_check(1'b0, "R5 40 below 50");
        errs(1);
        settle_check(1'b1, "R5 equality 50 trips");
        ticks(10);
        settle_check(1'b1, "R6 equality 40 holds");
        ticks(1);
        settle_check(1'b0, "R6 39 releases");
        thr_set_i = 8'd128;
        thr_clr_i = 8'd112;
    endtask

    task automatic run_rate(input int lines_per_err, input int periods);
        for (int p = 0; p < periods; p++) begin
            for (int l = 0; l < lines_per_err; l++) begin
                if (l == 0) errs(1);
                ticks(1);
                repeat (2) @(negedge clk);
            end
        end
    endtask

    task automatic t_rate_balance();
        do_reset();
        run_rate(9, 200);
        settle_check(1'b1, "R8 one per 9 lines raises");
        run_rate(11, 150);
        settle_check(1'b0, "R8 one per 11 lines clears");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        mon_en = 1'b1;
        t_reset_state();
        t_empty_floor();
        t_full_saturate();
        t_both_same_cycle();
        t_custom_levels();
        t_rate_balance();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule